// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small fully associative translation cache that sits between an address generator and memory. Each access presents a virtual address, the identifier of the running address space and a strobe. The upper bits of the address (the virtual page number) are compared against every stored entry at once. An entry takes part only if it is valid and its stored address-space identifier equals the current one. On a match the block returns, in the same cycle, the physical address built from the stored frame number and the untouched page offset. When nothing matches it raises a miss, and an external page walker answers later with a refill entry.

A refill is written into the entry that already holds the same page and identifier, if there is one. Otherwise it goes into the lowest-numbered free slot, and when every slot is in use it goes to the slot a round-robin pointer selects. Software-driven invalidation can drop every entry in one cycle or only the entries that belong to one address space. The page size is a power of two set by the offset-width parameter.

Top module: `asid_tlb`

## Requirements
- R1: When `lk_valid` is high and a valid entry holds the presented page number and identifier, `lk_hit` is 1 in that same cycle and `lk_paddr` equals the stored frame number above the offset bits of `lk_vaddr`. If several entries match, the lowest-numbered one is used.
- R2: When `lk_valid` is high and no entry matches, `lk_miss` is 1 and `lk_hit` is 0. When `lk_valid` is low, both are 0. `lk_hit` and `lk_miss` are never high together.
- R3: An entry whose stored identifier differs from `lk_asid` never produces a hit, even when its page number matches.
- R4: The offset width `OFS_W` may be set from 9 to 13, so the page size ranges from 512 to 8192 bytes. The page number is `lk_vaddr[VA_W-1:OFS_W]`, and `lk_paddr[OFS_W-1:0]` always equals `lk_vaddr[OFS_W-1:0]` on a hit.
- R5: After reset every entry is invalid, so every lookup misses, and the round-robin pointer is at slot 0.
- R6: A refill presented with `fill_valid` is visible to lookups from the next cycle on. A lookup in the refill cycle itself sees the earlier contents.
- R7: A refill that matches no entry goes into the lowest-numbered invalid slot. If no slot is invalid, it replaces the slot named by the round-robin pointer, and the pointer then advances by one, wrapping from the last slot to slot 0. The pointer moves only on such replacements.
- R8: A refill whose page number and identifier match a valid entry overwrites the frame number of that entry. No duplicate is created and the pointer does not move.
- R9: `flush_all` invalidates every entry, with effect from the next cycle.
- R10: `flush_one` invalidates only the entries whose identifier equals `flush_asid`. All other entries stay valid.
- R11: When a flush and a refill fall in the same cycle, the flush takes effect first. Slot choice and duplicate detection use the contents left after the flush, and the refilled entry survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Identifier of the current address space |
| lk_hit | output | 1 | Translation found (same cycle) |
| lk_miss | output | 1 | Strobed lookup found no entry |
| lk_paddr | output | PA_W | Frame number joined with page offset |
| fill_valid | input | 1 | Refill entry present |
| fill_vpn | input | VA_W-OFS_W | Refill page number |
| fill_asid | input | ASID_W | Refill identifier |
| fill_pfn | input | PA_W-OFS_W | Refill frame number |
| flush_all | input | 1 | Invalidate every entry |
| flush_one | input | 1 | Invalidate entries of one identifier |
| flush_asid | input | ASID_W | Identifier selected for `flush_one` |

## Verification
A flush and a refill can land on the same clock edge, and the outcome depends on which is applied first. The bench provokes this in directed form by flushing one identifier while a refill for that same identifier arrives, and again during a long pseudo-random phase where flushes, refills and lookups overlap freely. The result is judged on the cycles that follow: the refilled page must hit, every other page of the flushed identifier must miss, and the slot chosen for the refill must be consistent with the contents left after the flush. A lookup that coincides with a refill is judged as well, and it must see the contents from before the refill.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  typedef enum logic [1:0] {
    FILL_NONE   = 2'd0,
    FILL_UPDATE = 2'd1,
    FILL_FREE   = 2'd2,
    FILL_EVICT  = 2'd3
  } fill_kind_e;

endpackage

// File: rtl/asid_tlb_match.sv
module asid_tlb_match #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        vld,
  input  logic [N*VPN_W-1:0]  tag_vpn,
  input  logic [N*ASID_W-1:0] tag_asid,
  input  logic [VPN_W-1:0]    key_vpn,
  input  logic [ASID_W-1:0]   key_asid,
  output logic                any,
  output logic [IDX_W-1:0]    idx
);

  logic [N-1:0] hitv;

  // Parallel comparators, one per entry
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hitv[g] = vld[g]
                   && (tag_vpn[g*VPN_W +: VPN_W] == key_vpn)
                   && (tag_asid[g*ASID_W +: ASID_W] == key_asid);
  end

  // Lowest index wins
  always_comb begin
    any = |hitv;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hitv[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/asid_tlb_store.sv
module asid_tlb_store #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush_all,
  input  logic                flush_one,
  input  logic [ASID_W-1:0]   flush_asid,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic [PFN_W-1:0]    wr_pfn,
  output logic [N-1:0]        vld_q,
  output logic [N-1:0]        vld_post,
  output logic [N*VPN_W-1:0]  tag_vpn,
  output logic [N*ASID_W-1:0] tag_asid,
  output logic [N*PFN_W-1:0]  data_pfn
);

  logic [N-1:0] vld_d;
  logic [N-1:0] wr_sel;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [PFN_W-1:0]  pfn_q;

    assign wr_sel[g] = wr_en && (wr_idx == IDX_W'(g));

    // Flush is applied before any write of this cycle
    assign vld_post[g] = vld_q[g] && !flush_all
                       && !(flush_one && (asid_q == flush_asid));

    // Payload: no reset, written under clock enable
    always_ff @(posedge clk) begin
      if (wr_sel[g]) begin
        vpn_q  <= wr_vpn;
        asid_q <= wr_asid;
        pfn_q  <= wr_pfn;
      end
    end

    assign tag_vpn[g*VPN_W +: VPN_W]    = vpn_q;
    assign tag_asid[g*ASID_W +: ASID_W] = asid_q;
    assign data_pfn[g*PFN_W +: PFN_W]   = pfn_q;
  end

  always_comb begin
    vld_d = vld_post | wr_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim
  import asid_tlb_pkg::*;
#(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_valid,
  input  logic [N-1:0]     vld_post,
  input  logic             dup_any,
  input  logic [IDX_W-1:0] dup_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx
);

  fill_kind_e       kind;
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_q, rr_d;
  logic             rr_en;

  // Lowest free slot
  always_comb begin
    free_any = ~&vld_post;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_post[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    kind   = FILL_NONE;
    wr_idx = rr_q;
    if (fill_valid) begin
      if (dup_any) begin
        kind   = FILL_UPDATE;
        wr_idx = dup_idx;
      end else if (free_any) begin
        kind   = FILL_FREE;
        wr_idx = free_idx;
      end else begin
        kind   = FILL_EVICT;
        wr_idx = rr_q;
      end
    end
    wr_en = (kind != FILL_NONE);
  end

  // Round-robin pointer: moves only on an eviction
  always_comb begin
    rr_en = (kind == FILL_EVICT);
    rr_d  = (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (rr_en) rr_q <= rr_d;
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFS_W   = 12,
  parameter int ASID_W  = 8,
  parameter int ENTRIES = 8,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PFN_W  = PA_W - OFS_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PA_W-1:0]   lk_paddr,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              flush_all,
  input  logic              flush_one,
  input  logic [ASID_W-1:0] flush_asid
);

  logic [ENTRIES-1:0]        vld_q, vld_post;
  logic [ENTRIES*VPN_W-1:0]  tag_vpn;
  logic [ENTRIES*ASID_W-1:0] tag_asid;
  logic [ENTRIES*PFN_W-1:0]  data_pfn;
  logic                      lk_any, dup_any, wr_en;
  logic [IDX_W-1:0]          lk_idx, dup_idx, wr_idx;
  logic [PFN_W-1:0]          hit_pfn;

  asid_tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .vld      (vld_q),
    .tag_vpn  (tag_vpn),
    .tag_asid (tag_asid),
    .key_vpn  (lk_vaddr[VA_W-1:OFS_W]),
    .key_asid (lk_asid),
    .any      (lk_any),
    .idx      (lk_idx)
  );

  // Duplicate search against the post-flush contents
  asid_tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
    .vld      (vld_post),
    .tag_vpn  (tag_vpn),
    .tag_asid (tag_asid),
    .key_vpn  (fill_vpn),
    .key_asid (fill_asid),
    .any      (dup_any),
    .idx      (dup_idx)
  );

  asid_tlb_victim #(.N(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_valid (fill_valid),
    .vld_post   (vld_post),
    .dup_any    (dup_any),
    .dup_idx    (dup_idx),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx)
  );

  asid_tlb_store #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_all  (flush_all),
    .flush_one  (flush_one),
    .flush_asid (flush_asid),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_vpn     (fill_vpn),
    .wr_asid    (fill_asid),
    .wr_pfn     (fill_pfn),
    .vld_q      (vld_q),
    .vld_post   (vld_post),
    .tag_vpn    (tag_vpn),
    .tag_asid   (tag_asid),
    .data_pfn   (data_pfn)
  );

  always_comb begin
    hit_pfn  = data_pfn[lk_idx*PFN_W +: PFN_W];
    lk_hit   = lk_valid && lk_any;
    lk_miss  = lk_valid && !lk_any;
    lk_paddr = {hit_pfn, lk_vaddr[OFS_W-1:0]};
  end

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int OFS_W  = 12,
  parameter int ASID_W = 8,
  localparam int VPN_W = VA_W - OFS_W,
  localparam int PFN_W = PA_W - OFS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [VA_W-1:0]   lk_vaddr,
  input logic [ASID_W-1:0] lk_asid,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic [PA_W-1:0]   lk_paddr,
  input logic              fill_valid,
  input logic [VPN_W-1:0]  fill_vpn,
  input logic [ASID_W-1:0] fill_asid,
  input logic [PFN_W-1:0]  fill_pfn,
  input logic              flush_all
);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));

  assert_hit_xor_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit != lk_miss));

  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]));

  assert_flush_all_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !fill_valid) |=> !lk_hit);

  assert_refill_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(fill_valid) && (lk_vaddr[VA_W-1:OFS_W] == $past(fill_vpn))
     && (lk_asid == $past(fill_asid)))
    |-> (lk_hit && (lk_paddr[PA_W-1:OFS_W] == $past(fill_pfn))));

endmodule

bind asid_tlb asid_tlb_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .ASID_W(ASID_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_vaddr   (lk_vaddr),
  .lk_asid    (lk_asid),
  .lk_hit     (lk_hit),
  .lk_miss    (lk_miss),
  .lk_paddr   (lk_paddr),
  .fill_valid (fill_valid),
  .fill_vpn   (fill_vpn),
  .fill_asid  (fill_asid),
  .fill_pfn   (fill_pfn),
  .flush_all  (flush_all)
);

// File: tb/asid_tlb_tb_top.sv
module asid_tlb_tb_top;

  localparam int VA_W = 32, PA_W = 32, OFS_W = 12, ASID_W = 8, N = 8;
  localparam int VPN_W = VA_W - OFS_W, PFN_W = PA_W - OFS_W;

  logic              clk, rst_n;
  logic              lk_valid, lk_hit, lk_miss;
  logic [VA_W-1:0]   lk_vaddr;
  logic [ASID_W-1:0] lk_asid;
  logic [PA_W-1:0]   lk_paddr;
  logic              fill_valid, flush_all, flush_one;
  logic [VPN_W-1:0]  fill_vpn;
  logic [ASID_W-1:0] fill_asid, flush_asid;
  logic [PFN_W-1:0]  fill_pfn;

  int checks = 0, fails = 0;
  bit done = 0;

  // Behavioural reference state
  bit               m_v    [N];
  logic [VPN_W-1:0] m_vpn  [N];
  logic [7:0]       m_asid [N];
  logic [PFN_W-1:0] m_pfn  [N];
  int               m_rr;

  asid_tlb dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .flush_all(flush_all), .flush_one(flush_one),
    .flush_asid(flush_asid)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic report();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      report();
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive, compare against the reference, advance the reference
  task automatic step(string tag, bit lv, logic [VPN_W-1:0] lvpn, logic [OFS_W-1:0] lofs,
                      logic [7:0] las, bit fv, logic [VPN_W-1:0] fvpn, logic [7:0] fas,
                      logic [PFN_W-1:0] fpfn, bit fa, bit fo, logic [7:0] foa);
    bit e_hit;
    logic [PFN_W-1:0] e_pfn;
    bit post [N];
    int slot;
    lk_valid = lv; lk_vaddr = {lvpn, lofs}; lk_asid = las;
    fill_valid = fv; fill_vpn = fvpn; fill_asid = fas; fill_pfn = fpfn;
    flush_all = fa; flush_one = fo; flush_asid = foa;
    #1;
    e_hit = 0; e_pfn = '0;
    for (int i = 0; i < N; i++)
      if (!e_hit && m_v[i] && m_vpn[i] == lvpn && m_asid[i] == las) begin
        e_hit = 1; e_pfn = m_pfn[i];
      end
    chk(tag, {lk_hit, lk_miss}, {lv && e_hit, lv && !e_hit}, "hit/miss");
    if (lv && e_hit) chk(tag, lk_paddr, {e_pfn, lofs}, "paddr");
    @(posedge clk);
    for (int i = 0; i < N; i++)
      post[i] = m_v[i] && !fa && !(fo && m_asid[i] == foa);
    if (fv) begin
      slot = -1;
      for (int i = 0; i < N; i++)
        if (slot < 0 && post[i] && m_vpn[i] == fvpn && m_asid[i] == fas) slot = i;
      if (slot < 0)
        for (int i = 0; i < N; i++) if (slot < 0 && !post[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr; m_rr = (m_rr + 1) % N;
      end
      post[slot] = 1; m_vpn[slot] = fvpn; m_asid[slot] = fas; m_pfn[slot] = fpfn;
    end
    for (int i = 0; i < N; i++) m_v[i] = post[i];
    @(negedge clk);
  endtask

  task automatic look(string tag, logic [VPN_W-1:0] vpn, logic [7:0] as);
    step(tag, 1, vpn, 12'hA5C, as, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(string tag, logic [VPN_W-1:0] vpn, logic [7:0] as, logic [PFN_W-1:0] pfn);
    step(tag, 0, 0, 0, 0, 1, vpn, as, pfn, 0, 0, 0);
  endtask

  initial begin
    logic [31:0] lf;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_rr = 0;
    rst_n = 0;
    lk_valid = 0; lk_vaddr = 0; lk_asid = 0;
    fill_valid = 0; fill_vpn = 0; fill_asid = 0; fill_pfn = 0;
    flush_all = 0; flush_one = 0; flush_asid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R5: empty after reset
    lk_valid = 1; lk_vaddr = 32'h0001_0123; lk_asid = 1; #1;
    chk("R5", {lk_hit, lk_miss}, 2'b01, "reset lookup");
    lk_valid = 0; @(negedge clk);

    // R7 free slots, R6 lookup in the refill cycle sees old contents
    for (int i = 0; i < N; i++)
      step("R6", 1, VPN_W'(16 + i), 12'h010, 1, 1, VPN_W'(16 + i), 1, PFN_W'(256 + i), 0, 0, 0);
    for (int i = 0; i < N; i++) look("R1", VPN_W'(16 + i), 1);
    step("R4", 1, 20'd19, 12'hFFF, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 20'd19, 12'h000, 1, 0, 0, 0, 0, 0, 0, 0);
    look("R3", 20'd17, 2);
    step("R2", 0, 20'd17, 12'h001, 1, 0, 0, 0, 0, 0, 0, 0);
    look("R2", 20'd99, 1);

    // R7 eviction via round robin
    fill("R7", 20'd40, 1, 20'h400);
    fill("R7", 20'd41, 1, 20'h401);
    look("R7", 20'd16, 1);
    look("R7", 20'd17, 1);
    look("R7", 20'd18, 1);
    look("R7", 20'd41, 1);

    // R8 refill of an existing entry updates in place
    fill("R8", 20'd20, 1, 20'hBEEF);
    look("R8", 20'd20, 1);
    fill("R8", 20'd42, 1, 20'h402);
    look("R8", 20'd18, 1);
    look("R8", 20'd20, 1);

    // R10 selective flush
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    look("R10", 20'd20, 1);
    fill("R10", 20'd20, 2, 20'h222);
    fill("R10", 20'd21, 3, 20'h333);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3);
    look("R10", 20'd20, 2);
    look("R10", 20'd21, 3);

    // R11 flush of an identifier and refill of the same identifier together
    fill("R11", 20'd50, 4, 20'h550);
    step("R11", 0, 0, 0, 0, 1, 20'd51, 4, 20'h551, 0, 1, 4);
    look("R11", 20'd50, 4);
    look("R11", 20'd51, 4);
    step("R11", 0, 0, 0, 0, 1, 20'd52, 5, 20'h552, 1, 0, 0);
    look("R11", 20'd52, 5);
    look("R11", 20'd20, 2);

    // R9 full flush
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    look("R9", 20'd52, 5);

    // Mixed traffic: flushes, refills and lookups overlapping
    lf = 32'hACE1_2345;
    for (int k = 0; k < 600; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step("R11", lf[0], VPN_W'(lf[4:2]), OFS_W'(lf[15:4]), 8'(lf[6:5]),
           lf[7] | lf[8], VPN_W'(lf[11:9]), 8'(lf[13:12]), PFN_W'(lf[31:14]),
           (lf[20:16] == 5'd0), (lf[24:21] == 4'd0), 8'(lf[26:25]));
    end

    done = 1;
    report();
  end

endmodule